// File: doc/BRIEF.md
# Data Object Mailbox with Echo Responder

This block is a register-level mailbox that carries variable-length data objects, one 32-bit dword at a time, from a requester to a responder and carries the reply back. The requester reaches four registers through a simple configuration write/read port: a control register, a status register, a write mailbox and a read mailbox. Request dwords collect in an inbound FIFO. When the requester issues a go command, the object's length is checked and the object is handed to the responder. The responder puts a complete response object into an outbound FIFO and then raises a ready flag. The requester drains the response one dword at a time.

The responder here is an echo engine. It moves every request dword, header first, into the outbound FIFO at one dword per cycle, so the response is an exact copy of the request. An object's first header dword holds a vendor ID in bits [15:0] and an object type in bits [31:16]. The second header dword holds the total object length in dwords, counting both header dwords.

A controller with three states drives the sequence. IDLE accepts request writes. COPY moves dwords and reports busy. READY holds the response for draining. The named transitions are:

- go_ok: IDLE to COPY.
- go_bad: IDLE to IDLE, setting the error bit.
- copy_done: COPY to READY, on the last dword moved.
- drained: READY to IDLE, on the advance past the last dword.
- abort: any state to IDLE.

Top module: `objx_mailbox`

## Requirements
- R1: After reset the status register (address 1) reads 0 and the read mailbox (address 3) reads 0.
- R2: A write to address 0 with bit 0 set (go) is accepted in IDLE when the inbound count is at least 2 and equals the length in the second header dword. Busy (status bit 0) is then high from the cycle after go for exactly N cycles, where N is the object length, and ready (status bit 2) rises as busy falls.
- R3: While ready is high, reading address 3 returns the current response dword and writing any value to address 3 advances to the next dword. Ready falls on the advance past the last dword, and address 3 reads 0 whenever ready is low.
- R4: The response is the request object echoed in order, header dwords included (dword 0: type in [31:16], vendor ID in [15:0]; dword 1: length).
- R5: A go in IDLE whose inbound count is below 2 or differs from the length field sets the error bit (status bit 1), leaves busy and ready low, and discards the inbound object.
- R6: Writes to the write mailbox (address 2) while busy is high are ignored.
- R7: Writing address 0 with bit 1 set (abort) clears busy, ready and error by the next cycle and flushes both FIFOs, leaving no stale request or response data.
- R8: An object with more dwords than the FIFO depth sets the error bit on go. An object of exactly the depth is accepted.
- R9: A go written while busy or ready is high has no effect on the response in progress.
- R10: The error bit stays set until an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 status, 2 write mailbox, 3 read mailbox |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected register (combinational) |

## Verification
A configuration write takes effect at the clock edge that samples it, so the status register, read on the following falling edge, already shows the result. This holds for error after a bad go, for abort clearing busy, ready and error, and for ready falling after the final advance.

After a good go, busy is high at the first falling edge and stays high through N-1 further falling edges. Ready appears at falling edge N, where N is the object length. The bench drives on falling edges and counts those edges exactly, including when other writes are inserted during COPY.

The read mailbox is combinational, so each response dword is sampled shortly after the falling edge, before the write that advances it.

// File: rtl/objx_pkg.sv
package objx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COPY  = 2'd1,
        ST_READY = 2'd2
    } mbx_state_e;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_STATUS = 2'd1;
    localparam logic [1:0] REG_WMB    = 2'd2;
    localparam logic [1:0] REG_RMB    = 2'd3;

    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_ABORT_BIT = 1;
endpackage

// File: rtl/objx_fifo.sv
module objx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= wdata;
    end

    assign head  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/objx_ctrl_fsm.sv
module objx_ctrl_fsm
    import objx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic abort,
    input  logic obj_ok,
    input  logic in_last,
    input  logic rd_adv,
    input  logic out_last,
    output logic busy,
    output logic ready,
    output logic err,
    output logic copy_en,
    output logic in_flush,
    output logic out_flush
);
    mbx_state_e state_q, state_d;
    logic       err_set;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || abort) err <= 1'b0;
        else if (err_set)    err <= 1'b1;
    end

    always_comb begin
        state_d   = state_q;
        busy      = 1'b0;
        ready     = 1'b0;
        copy_en   = 1'b0;
        err_set   = 1'b0;
        in_flush  = abort;
        out_flush = abort;
        unique case (state_q)
            ST_IDLE: begin
                if (!abort && go) begin
                    if (obj_ok) begin
                        state_d = ST_COPY;
                    end else begin
                        err_set  = 1'b1;
                        in_flush = 1'b1;
                    end
                end
            end
            ST_COPY: begin
                busy    = 1'b1;
                copy_en = !abort;
                if (abort)        state_d = ST_IDLE;
                else if (in_last) state_d = ST_READY;
            end
            ST_READY: begin
                ready = 1'b1;
                if (abort)                    state_d = ST_IDLE;
                else if (rd_adv && out_last)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !ready && !err));
    p_bad_go_errs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go && !abort && !obj_ok) |=> (err && !busy && !ready));
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !abort) |=> err);
endmodule

// File: rtl/objx_mailbox.sv
module objx_mailbox
    import objx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata
);
    logic          go_req, abort_req, wmb_wr, rmb_wr;
    logic          busy, ready, err, copy_en, in_flush, out_flush;
    logic          in_push, in_full, in_empty, out_full, out_empty;
    logic [31:0]   in_head, out_head, hdr_len_q;
    logic [CW-1:0] in_count, out_count;
    logic          ovf_q, obj_ok, out_pop;

    assign go_req    = cfg_wr && cfg_addr == REG_CTRL && cfg_wdata[CTRL_GO_BIT];
    assign abort_req = cfg_wr && cfg_addr == REG_CTRL && cfg_wdata[CTRL_ABORT_BIT];
    assign wmb_wr    = cfg_wr && cfg_addr == REG_WMB;
    assign rmb_wr    = cfg_wr && cfg_addr == REG_RMB;

    assign in_push = wmb_wr && !busy && !in_full;
    assign out_pop = rmb_wr && ready && !out_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q     <= 1'b0;
            hdr_len_q <= '0;
        end else begin
            if (abort_req || (go_req && !busy && !ready)) ovf_q <= 1'b0;
            else if (wmb_wr && !busy && in_full)          ovf_q <= 1'b1;
            if (in_push && in_count == CW'(1)) hdr_len_q <= cfg_wdata;
        end
    end

    assign obj_ok = (in_count >= CW'(2)) && (hdr_len_q == 32'(in_count)) && !ovf_q;

    objx_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_req),
        .abort     (abort_req),
        .obj_ok    (obj_ok),
        .in_last   (in_count == CW'(1)),
        .rd_adv    (rmb_wr),
        .out_last  (out_count == CW'(1)),
        .busy      (busy),
        .ready     (ready),
        .err       (err),
        .copy_en   (copy_en),
        .in_flush  (in_flush),
        .out_flush (out_flush)
    );

    objx_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_in_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (in_flush),
        .push  (in_push),
        .wdata (cfg_wdata),
        .pop   (copy_en && !in_empty),
        .head  (in_head),
        .count (in_count),
        .full  (in_full),
        .empty (in_empty)
    );

    objx_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_out_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (out_flush),
        .push  (copy_en && !in_empty && !out_full),
        .wdata (in_head),
        .pop   (out_pop),
        .head  (out_head),
        .count (out_count),
        .full  (out_full),
        .empty (out_empty)
    );

    always_comb begin
        unique case (cfg_addr)
            REG_STATUS: cfg_rdata = {29'd0, ready, err, busy};
            REG_RMB:    cfg_rdata = ready ? out_head : 32'd0;
            default:    cfg_rdata = 32'd0;
        endcase
    end

    p_ready_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !out_empty);
    p_busy_blocks_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_push);
    p_busy_then_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort_req) |=> (busy || ready));
endmodule

// File: tb/objx_mailbox_tb_top.sv
module objx_mailbox_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    objx_mailbox #(.DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] obj_dw(input int i, input logic [15:0] vid,
                                           input logic [15:0] typ, input logic [31:0] lenf,
                                           input logic [31:0] base);
        if (i == 0)      return {typ, vid};
        else if (i == 1) return lenf;
        else             return base + 32'(i);
    endfunction

    task automatic send_obj(input int n, input logic [15:0] vid, input logic [15:0] typ,
                            input logic [31:0] lenf, input logic [31:0] base);
        for (int i = 0; i < n; i++) cfg_write(2'd2, obj_dw(i, vid, typ, lenf, base));
    endtask

    task automatic go_and_wait(input int n, input string req);
        logic [31:0] s;
        cfg_write(2'd0, 32'h1);
        cfg_read(2'd1, s); chk({req, " busy after go"}, s, 32'h1);
        repeat (n - 1) @(negedge clk);
        cfg_read(2'd1, s); chk({req, " busy on last copy cycle"}, s, 32'h1);
        @(negedge clk);
        cfg_read(2'd1, s); chk({req, " ready after copy"}, s, 32'h4);
    endtask

    task automatic drain(input int n, input logic [15:0] vid, input logic [15:0] typ,
                         input logic [31:0] lenf, input logic [31:0] base, input string req);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            cfg_read(2'd1, d); chk({req, " ready during drain"}, d[2], 32'h1);
            cfg_read(2'd3, d); chk({req, " echo dword"}, d, obj_dw(i, vid, typ, lenf, base));
            cfg_write(2'd3, 32'hFFFF_FFFF);
        end
        cfg_read(2'd1, d); chk({req, " ready low after drain"}, d, 32'h0);
        cfg_read(2'd3, d); chk({req, " rmb zero when not ready"}, d, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        cfg_read(2'd1, d); chk("R1 status at reset", d, 32'h0);
        cfg_read(2'd3, d); chk("R1 rmb at reset", d, 32'h0);
    endtask

    task automatic t_echo();
        send_obj(4, 16'hABCD, 16'h0001, 32'd4, 32'h1000);
        go_and_wait(4, "R2");
        drain(4, 16'hABCD, 16'h0001, 32'd4, 32'h1000, "R3 R4");
        send_obj(2, 16'h1234, 16'h00F0, 32'd2, 32'h0);
        go_and_wait(2, "R2 min length");
        drain(2, 16'h1234, 16'h00F0, 32'd2, 32'h0, "R4 min length");
    endtask

    task automatic t_mismatch();
        logic [31:0] s;
        send_obj(3, 16'h5555, 16'h0002, 32'd5, 32'h2000);
        cfg_write(2'd0, 32'h1);
        cfg_read(2'd1, s); chk("R5 length mismatch sets error", s, 32'h2);
        repeat (3) @(negedge clk);
        cfg_read(2'd1, s); chk("R10 error sticky", s, 32'h2);
        cfg_write(2'd0, 32'h2);
        cfg_read(2'd1, s); chk("R7 abort clears error", s, 32'h0);
        cfg_write(2'd0, 32'h1);
        cfg_read(2'd1, s); chk("R5 go on empty inbound errors", s, 32'h2);
        cfg_write(2'd0, 32'h2);
        send_obj(3, 16'h6666, 16'h0003, 32'd3, 32'h2100);
        go_and_wait(3, "R5 discarded object gone");
        drain(3, 16'h6666, 16'h0003, 32'd3, 32'h2100, "R5 next object clean");
    endtask

    task automatic t_busy_ignore();
        send_obj(6, 16'h7777, 16'h0004, 32'd6, 32'h3000);
        cfg_write(2'd0, 32'h1);
        cfg_write(2'd2, 32'hDEAD_BEEF);
        cfg_write(2'd0, 32'h1);
        repeat (3) @(negedge clk);
        begin
            logic [31:0] s;
            cfg_read(2'd1, s); chk("R6 R9 still busy", s, 32'h1);
            @(negedge clk);
            cfg_read(2'd1, s); chk("R6 R9 ready on schedule", s, 32'h4);
            cfg_write(2'd0, 32'h1);
            cfg_read(2'd1, s); chk("R9 go while ready ignored", s, 32'h4);
        end
        drain(6, 16'h7777, 16'h0004, 32'd6, 32'h3000, "R6 response unchanged");
        send_obj(2, 16'h8888, 16'h0005, 32'd2, 32'h0);
        go_and_wait(2, "R6 busy write left no residue");
        drain(2, 16'h8888, 16'h0005, 32'd2, 32'h0, "R6 clean follow-up");
    endtask

    task automatic t_abort();
        logic [31:0] s;
        send_obj(6, 16'h9999, 16'h0006, 32'd6, 32'h4000);
        cfg_write(2'd0, 32'h1);
        cfg_write(2'd0, 32'h2);
        cfg_read(2'd1, s); chk("R7 abort during copy", s, 32'h0);
        send_obj(4, 16'hAAAA, 16'h0007, 32'd4, 32'h5000);
        go_and_wait(4, "R7 after copy abort");
        cfg_write(2'd3, 32'h0);
        cfg_write(2'd0, 32'h2);
        cfg_read(2'd1, s); chk("R7 abort during ready", s, 32'h0);
        cfg_read(2'd3, s); chk("R7 rmb after abort", s, 32'h0);
        send_obj(3, 16'hBBBB, 16'h0008, 32'd3, 32'h6000);
        go_and_wait(3, "R7 after ready abort");
        drain(3, 16'hBBBB, 16'h0008, 32'd3, 32'h6000, "R7 no stale response");
    endtask

    task automatic t_overflow();
        logic [31:0] s;
        send_obj(DEPTH + 1, 16'hCCCC, 16'h0009, 32'(DEPTH + 1), 32'h7000);
        cfg_write(2'd0, 32'h1);
        cfg_read(2'd1, s); chk("R8 oversize object errors", s, 32'h2);
        cfg_write(2'd0, 32'h2);
        send_obj(DEPTH, 16'hDDDD, 16'h000A, 32'(DEPTH), 32'h8000);
        go_and_wait(DEPTH, "R8 full-depth object");
        drain(DEPTH, 16'hDDDD, 16'h000A, 32'(DEPTH), 32'h8000, "R8 full-depth echo");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_echo();
        t_mismatch();
        t_busy_ignore();
        t_abort();
        t_overflow();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule